// File: doc/BRIEF.md
# Watchdog Timer With Locked Control Register

This block supervises software with a timeout counter that advances on a slow timebase strobe (128 ticks per second). Software must restart the counter before it expires. On expiry the block either asks for a system reset or raises an interrupt, depending on a response-select bit. A status flag records that an expiry happened. A timeout code of 8 asks for a reset at once, which lets software force a controlled restart.

All configuration sits in one control byte, reached through a simple write strobe and a read-back bus. The register is locked. A write that sets bit 0 while the register is locked only unlocks it. The next write is then accepted in full, and the lock returns by itself. Any accepted write also restarts the counter, so rewriting the enable bit serves as the software kick.

Control byte layout: bits [7:4] are the timeout code, bit 3 is the response select (1 = interrupt, 0 = reset), bit 2 is the expiry flag, bit 1 is the enable, and bit 0 is the unlock bit.

Top module: `wdog_guard`

## Requirements
- R1: After reset, rd_data reads 0x70 (timeout code 7, everything else clear), and rst_req and irq are low.
- R2: While the register is locked (bit 0 reads 0), a write with wr_data[0]=1 only sets the unlock bit; all other fields stay unchanged. A locked write with wr_data[0]=0 changes nothing.
- R3: While unlocked, a write loads the timeout code (bits [7:4]), the response select (bit 3) and the enable (bit 1), and the unlock bit reads 0 after the write, whatever bit 0 of the data was.
- R4: With enable set and timeout code c in 0..7, expiry happens on the (2<<c)-th tick counted since the last accepted write. Ticks do not count while enable is clear.
- R5: On expiry with response select 0, rst_req is high for exactly one cycle (the cycle after the clock edge that sampled the final tick), the flag sets, and counting restarts from zero.
- R6: On expiry with response select 1, the flag sets and rst_req stays low. irq equals flag AND response select, so it remains high until the flag is cleared.
- R7: The flag is cleared only by reset or by an accepted write with bit 2 = 0. An accepted write with bit 2 = 1 never sets it.
- R8: Every accepted write restarts the count from zero (kick). A tick in the same cycle as an accepted write is not counted.
- R9: An accepted write of code 8 with bit 1 = 1 makes rst_req high for one cycle after the write, in either response mode, and sets the flag. While code 8 is stored, counting halts.
- R10: An accepted write carrying a code of 9..15 leaves the stored timeout code unchanged. The other fields of that write still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe (128 Hz) |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read-back |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Interrupt request (level) |

## Verification
The hardest case to reach is an expiry at the longest code, because it needs 256 separate ticks after a two-write unlock-and-configure sequence. The bench sweeps every code in both response modes and checks the outputs after every tick, so both the final tick and the tick before it are covered. Two more corners need exact cycle alignment: a tick that arrives in the same cycle as an accepted write, and a kick that lands one tick before expiry. The bench drives both cases directly, with the strobes set on the same falling edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Control byte fields (byte layout: code[7:4] rsp[3] flag[2] en[1] unlk[0])
  typedef struct packed {
    logic [3:0] code;
    logic       rsp_irq;
    logic       flag;
    logic       en;
    logic       unlk;
  } wdog_ctrl_t;

  localparam logic [7:0] CTRL_RST_VAL = 8'h70;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int NUM_STEPS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       set_flag,
  output wdog_ctrl_t ctrl,
  output logic       accept,
  output logic       imm_fire
);

  localparam logic [3:0] IMM_CODE = 4'(NUM_STEPS);

  wdog_ctrl_t ctrl_n;
  logic       code_ok;
  logic       ctrl_ce;

  assign accept   = wr_en & ctrl.unlk;
  assign code_ok  = (wr_data[7:4] <= IMM_CODE);
  assign imm_fire = accept & code_ok & (wr_data[7:4] == IMM_CODE) & wr_data[1];
  assign ctrl_ce  = wr_en | set_flag;

  always_comb begin
    ctrl_n = ctrl;
    if (accept) begin
      if (code_ok) ctrl_n.code = wr_data[7:4];
      ctrl_n.rsp_irq = wr_data[3];
      ctrl_n.en      = wr_data[1];
      ctrl_n.flag    = ctrl.flag & wr_data[2];
      ctrl_n.unlk    = 1'b0;
    end else if (wr_en && wr_data[0]) begin
      ctrl_n.unlk = 1'b1;
    end
    if (set_flag) ctrl_n.flag = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= wdog_ctrl_t'(CTRL_RST_VAL);
    else if (ctrl_ce) ctrl <= ctrl_n;
  end

  // R3: lock returns after an accepted write
  a_r3_unlock_clears: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ctrl.unlk);

  // R2: locked write changes no configuration field
  a_r2_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctrl.unlk) |=> ($stable(ctrl.code) && $stable(ctrl.en) && $stable(ctrl.rsp_irq)));

  // R10: reserved codes leave the stored code alone
  a_r10_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (wr_data[7:4] > IMM_CODE)) |=> $stable(ctrl.code));

  // R7: flag only falls through an accepted write
  a_r7_flag_clear_src: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl.flag) |-> $past(accept));

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int NUM_STEPS  = 8,
  parameter int BASE_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic [3:0] code,
  input  logic       clr,
  output logic       timeout
);

  localparam int MAX_LIM = BASE_TICKS << (NUM_STEPS - 1);
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic [CNT_W-1:0] lim_tab [NUM_STEPS];
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             running;
  logic             last;
  logic             cnt_ce;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'(BASE_TICKS << g);
  end

  always_comb begin
    limit = '0;
    for (int i = 0; i < NUM_STEPS; i++)
      if (code == 4'(i)) limit = lim_tab[i];
  end

  assign running = en & (code < 4'(NUM_STEPS));
  assign last    = (cnt == limit - CNT_W'(1));
  assign timeout = running & tick & ~clr & last;
  assign cnt_ce  = clr | ~running | tick;

  always_comb begin
    if (clr || !running) cnt_n = '0;
    else if (last)       cnt_n = '0;
    else                 cnt_n = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_ce) cnt <= cnt_n;
  end

  // R4: count never reaches the selected limit
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < limit));

  // R8: an accepted write leaves the count at zero
  a_r8_kick_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/wdog_resp.sv
module wdog_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout,
  input  logic imm_fire,
  input  logic rsp_irq,
  output logic set_flag,
  output logic rst_req
);

  logic rst_req_n;

  assign set_flag  = timeout | imm_fire;
  assign rst_req_n = (timeout & ~rsp_irq) | imm_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= rst_req_n;
  end

  // R5: reset request is a single-cycle pulse
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R6: interrupt-mode expiry never requests reset
  a_r6_no_reset_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && rsp_irq && !imm_fire) |=> !rst_req);

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int NUM_STEPS  = 8,
  parameter int BASE_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       rst_req,
  output logic       irq
);

  wdog_ctrl_t ctrl;
  logic       accept;
  logic       imm_fire;
  logic       set_flag;
  logic       timeout;

  wdog_regs #(.NUM_STEPS(NUM_STEPS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .set_flag (set_flag),
    .ctrl     (ctrl),
    .accept   (accept),
    .imm_fire (imm_fire)
  );

  wdog_count #(.NUM_STEPS(NUM_STEPS), .BASE_TICKS(BASE_TICKS)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .en      (ctrl.en),
    .code    (ctrl.code),
    .clr     (accept),
    .timeout (timeout)
  );

  wdog_resp u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .timeout  (timeout),
    .imm_fire (imm_fire),
    .rsp_irq  (ctrl.rsp_irq),
    .set_flag (set_flag),
    .rst_req  (rst_req)
  );

  assign rd_data = 8'(ctrl);
  assign irq     = ctrl.flag & ctrl.rsp_irq;

  // R5: a reset request is always accompanied by the flag
  a_r5_flag_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ctrl.flag);

  // R9: immediate code with enable requests reset on the next cycle
  a_r9_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl.unlk && wr_data[7:4] == 4'(NUM_STEPS) && wr_data[1]) |=> rst_req);

endmodule

// File: tb/wdog_guard_test.sv
module wdog_guard_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       rst_req;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  wdog_guard uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic wr_tick(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00; tick = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] d);
    wr(8'h01);
    wr(d);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    check("R1 rd_data", rd_data, 8'h70);
    check("R1 rst_req", {7'd0, rst_req}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2: locked writes
    wr(8'hF2);
    check("R2 locked no-op", rd_data, 8'h70);
    wr(8'hFB);
    check("R2 unlock only", rd_data, 8'h71);
    // R3: accepted write loads and relocks
    wr(8'h2B);
    check("R3 accepted", rd_data, 8'h2A);
    wr(8'h01);
    wr(8'h00);
    check("R3 disable", rd_data, 8'h00);

    // R4: disabled ticks do not count
    for (int i = 0; i < 10; i++) tk();
    check("R4 disabled no reset", {7'd0, rst_req}, 8'h00);
    check("R4 disabled no flag", rd_data, 8'h00);

    // R4/R5/R6: sweep every code in both response modes
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++) begin
        automatic logic [7:0] cw = {4'(c), 1'(m), 1'b0, 1'b1, 1'b0};
        automatic int lim = 2 << c;
        cfg(cw);
        check("R3 cfg readback", rd_data, cw);
        for (int n = 1; n <= lim; n++) begin
          tk();
          check(m == 0 ? "R5 rst_req at tick" : "R6 rst_req at tick",
                {7'd0, rst_req}, {7'd0, (n == lim) && (m == 0)});
          check("R6 irq at tick", {7'd0, irq}, {7'd0, (n == lim) && (m == 1)});
        end
        check("R4 flag after expiry", {7'd0, rd_data[2]}, 8'h01);
        idle();
        check("R5 pulse ends", {7'd0, rst_req}, 8'h00);
        check("R6 irq holds", {7'd0, irq}, {7'd0, 1'(m)});
        // R7: writing flag=1 keeps it, writing 0 clears
        cfg(cw | 8'h04);
        check("R7 flag kept", {7'd0, rd_data[2]}, 8'h01);
        cfg(8'h00);
        check("R7 flag cleared", rd_data, 8'h00);
        check("R6 irq cleared", {7'd0, irq}, 8'h00);
      end
    end

    // R7: writing 1 never sets flag
    cfg(8'h06);
    check("R7 no set by write", rd_data, 8'h02);
    cfg(8'h00);

    // R5: restart after reset-mode expiry (code 0 = 2 ticks)
    cfg(8'h02);
    tk(); tk();
    check("R5 first expiry", {7'd0, rst_req}, 8'h01);
    tk();
    check("R5 restart tick1", {7'd0, rst_req}, 8'h00);
    tk();
    check("R5 second expiry", {7'd0, rst_req}, 8'h01);
    cfg(8'h00);

    // R8: kick one tick before expiry (code 1 = 4 ticks)
    cfg(8'h12);
    tk(); tk(); tk();
    cfg(8'h12);
    tk(); tk(); tk();
    check("R8 kicked no expiry", {7'd0, rst_req}, 8'h00);
    check("R8 kicked no flag", {7'd0, rd_data[2]}, 8'h00);
    tk();
    check("R8 expiry after kick", {7'd0, rst_req}, 8'h01);
    cfg(8'h00);

    // R8: tick coinciding with accepted write is not counted
    wr(8'h01);
    wr_tick(8'h02);
    tk();
    check("R8 coincident tick", {7'd0, rst_req}, 8'h00);
    tk();
    check("R8 expiry on second", {7'd0, rst_req}, 8'h01);
    cfg(8'h00);

    // R9: immediate code in both modes
    wr(8'h01);
    wr(8'h82);
    check("R9 immediate reset", {7'd0, rst_req}, 8'h01);
    check("R9 readback", rd_data, 8'h86);
    idle();
    check("R9 one cycle", {7'd0, rst_req}, 8'h00);
    for (int i = 0; i < 300; i++) tk();
    check("R9 halted", {7'd0, rst_req}, 8'h00);
    cfg(8'h00);
    wr(8'h01);
    wr(8'h8A);
    check("R9 immediate irq mode", {7'd0, rst_req}, 8'h01);
    cfg(8'h80);
    check("R9 disabled code8", {7'd0, rst_req}, 8'h00);
    cfg(8'h00);

    // R10: reserved codes keep the stored code
    cfg(8'h30);
    for (int c = 9; c < 16; c++) begin
      cfg({4'(c), 4'b1000});
      check("R10 reserved code", rd_data, 8'h38);
      check("R10 no reset", {7'd0, rst_req}, 8'h00);
      cfg(8'h30);
    end

    summary();
  end

endmodule